// File: doc/BRIEF.md
# Routed Level-Sensitive Interrupt Controller

This block collects nine level-sensitive interrupt sources and forwards them to three active-high interrupt request lines that feed a host interrupt controller. Each source has a polarity. Most sources take their polarity from a configuration register. Three sources have a polarity fixed in hardware.

Every output line owns one 32-bit register. The low half of that register enables sources onto the line. The upper half reports which sources are pending, and software acknowledges a source by writing a one to its bit there. A line raises its request when an enabled source is pending. Alongside each request the block reports the highest-numbered enabled pending source, which is the one software services first.

Software reaches the registers through a simple synchronous port with byte offsets. Writes take effect on the clock edge. Read data is registered and appears one cycle after the read strobe. A typical start-up writes 0x01FF0000 to all three line registers, which clears stale pending state and disables every source.

Top module: `lvl_irq_router`

## Requirements
- R1: After reset the polarity register, every enable mask and every pending bit are 0, and `irq_out` and `irq_id` are 0.
- R2: The polarity register is at offset 0x0. For the configurable sources 0 and 3 to 7, bit n = 1 makes source n active when its input is high, and bit n = 0 makes it active when its input is low.
- R3: Sources 1 and 8 are always active-high and source 2 is always active-low. Their polarity register bits are stored and read back but have no effect.
- R4: Line k's register is at offset 0x4 + 4*k. Its bits [8:0] are the enable mask for sources 0 to 8, and every write to it replaces the mask with write data bits [8:0].
- R5: Pending bit 16+n of each line is set on every clock edge at which source n is active, whatever the mask. While the input stays active, the bit sets again on the edge after an acknowledge.
- R6: Writing 1 to bit 16+n of a line register clears that line's pending bit for source n on that edge. Writing 0 there leaves the bit unchanged.
- R7: `irq_out[k]` is registered and goes to 1 on the edge after line k's mask ANDed with its pending bits becomes non-zero. It goes to 0 on the edge after that AND becomes zero.
- R8: `irq_id[4k+3:4k]` gives the highest-numbered source that is both enabled and pending on line k. It is updated at the same time as `irq_out[k]`, and is 0 when nothing is enabled and pending.
- R9: Line register reads return 0 in bits [15:9] and [31:25]. Offsets other than 0x0, 0x4, 0x8 and 0xC, including unaligned ones, read as 0 and ignore writes.
- R10: Writing 0x01FF0000 to each line register while the sources are inactive leaves all pending bits and all masks at 0.
- R11: `bus_rdata` is loaded on the edge where `bus_rd` is sampled high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 9 | Raw interrupt source levels |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 3 | Active-high request per output line |
| irq_id | output | 12 | Highest enabled pending source, 4 bits per line |

## Verification
The bench builds the block with its default parameters: nine sources, three lines, a five-bit byte address, and fixed polarity on sources 1, 2 and 8. The five-bit address reaches offsets above the last line register and unaligned offsets, so the unmapped-access rules can be tested. With nine sources, the 4-bit identifier and the pending half-word are both exercised up to source 8. Because the same source appears on all three lines, one input edge shows whether the lines keep their pending state apart, whether the masks gate the requests, and how an acknowledge behaves while the input is still active.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

  localparam int WORD_W = 32;

  // level after polarity: a bit is active when the pin equals its active level
  function automatic logic [WORD_W-1:0] level_active(input logic [WORD_W-1:0] pins,
                                                     input logic [WORD_W-1:0] act_lvl);
    return ~(pins ^ act_lvl);
  endfunction

  // index of the highest set bit, 0 when none is set
  function automatic logic [4:0] top_index(input logic [WORD_W-1:0] v);
    logic [4:0] idx;
    idx = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (v[i]) idx = 5'(i);
    end
    return idx;
  endfunction

endpackage

// File: rtl/lvl_irq_polarity.sv
module lvl_irq_polarity
  import lvl_irq_pkg::*;
#(
  parameter int          SRC_N      = 9,
  parameter logic [8:0]  FIXED_SEL  = 9'b1_0000_0110,
  parameter logic [8:0]  FIXED_HIGH = 9'b1_0000_0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SRC_N-1:0] cfg_wdata,
  input  logic [SRC_N-1:0] src_in,
  output logic [SRC_N-1:0] cfg_q,
  output logic [SRC_N-1:0] active
);

  logic [SRC_N-1:0] eff_lvl;
  logic [WORD_W-1:0] act_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  // fixed sources take their level from hardware, the rest from the register
  for (genvar i = 0; i < SRC_N; i++) begin : g_lvl
    if (FIXED_SEL[i]) begin : g_fixed
      assign eff_lvl[i] = FIXED_HIGH[i];
    end else begin : g_cfg
      assign eff_lvl[i] = cfg_q[i];
    end
  end

  assign act_wide = level_active(WORD_W'(src_in), WORD_W'(eff_lvl));
  assign active   = act_wide[SRC_N-1:0];

  // R3: a fixed active-high source whose pin is high is active regardless of the register
  a_r3_fixed_high : assert property (@(posedge clk) disable iff (!rst_n)
    ((src_in & FIXED_SEL[SRC_N-1:0] & FIXED_HIGH[SRC_N-1:0])
       & ~active) == '0);

endmodule

// File: rtl/lvl_irq_line.sv
module lvl_irq_line
  import lvl_irq_pkg::*;
#(
  parameter int SRC_N    = 9,
  parameter int ID_W     = 4,
  parameter int PEND_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic [SRC_N-1:0]  active,
  output logic [WORD_W-1:0] reg_word,
  output logic              irq,
  output logic [ID_W-1:0]   id
);

  logic [SRC_N-1:0] mask_q;
  logic [SRC_N-1:0] pend_q;
  logic [SRC_N-1:0] ack;
  logic [SRC_N-1:0] hit;
  logic [SRC_N-1:0] pend_d;
  logic [4:0]       top;

  assign ack    = wr_sel ? wdata[PEND_LSB +: SRC_N] : '0;
  // acknowledge wins on its own edge; a still-active level returns next edge
  assign pend_d = (pend_q | active) & ~ack;
  assign hit    = mask_q & pend_q;
  assign top    = top_index(WORD_W'(hit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pend_q <= '0;
      irq    <= 1'b0;
      id     <= '0;
    end else begin
      if (wr_sel) mask_q <= wdata[SRC_N-1:0];
      pend_q <= pend_d;
      irq    <= |hit;
      id     <= ID_W'(top);
    end
  end

  always_comb begin
    reg_word = '0;
    reg_word[SRC_N-1:0]           = mask_q;
    reg_word[PEND_LSB +: SRC_N]   = pend_q;
  end

  // R6: an acknowledged bit is clear on the edge after the write
  a_r6_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_sel) |-> (pend_q & $past(ack)) == '0);

  // R4: each write replaces the mask
  a_r4_mask_write : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(wr_sel) |-> mask_q == $past(wdata[SRC_N-1:0]));

  // R5: an active, unacknowledged source is pending on the next edge
  a_r5_level_sets : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (pend_q & $past(active & ~ack)) == $past(active & ~ack));

  // R7: request follows enabled pending state one edge later
  a_r7_irq_follows : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq == $past(|(mask_q & pend_q)));

  // R8: the reported identifier is the top bit of the enabled pending set
  a_r8_id_highest : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && irq |-> ($past(mask_q & pend_q) >> id) == SRC_N'(1));

endmodule

// File: rtl/lvl_irq_router.sv
module lvl_irq_router
  import lvl_irq_pkg::*;
#(
  parameter int          SRC_N      = 9,
  parameter int          LINE_N     = 3,
  parameter int          ADDR_W     = 5,
  parameter int          PEND_LSB   = 16,
  parameter logic [8:0]  FIXED_SEL  = 9'b1_0000_0110,
  parameter logic [8:0]  FIXED_HIGH = 9'b1_0000_0010,
  localparam int         ID_W       = $clog2(SRC_N),
  localparam int         CFG_OFS    = 0,
  localparam int         LINE_BASE  = 4,
  localparam int         LINE_STEP  = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SRC_N-1:0]       src_in,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [WORD_W-1:0]      bus_wdata,
  output logic [WORD_W-1:0]      bus_rdata,
  output logic [LINE_N-1:0]      irq_out,
  output logic [LINE_N*ID_W-1:0] irq_id
);

  logic              cfg_hit;
  logic [LINE_N-1:0] line_hit;
  logic              mapped;
  logic [SRC_N-1:0]  cfg_q;
  logic [SRC_N-1:0]  active;
  logic [WORD_W-1:0] line_word [LINE_N];
  logic [WORD_W-1:0] rd_word;

  assign cfg_hit = (bus_addr == ADDR_W'(CFG_OFS));
  for (genvar k = 0; k < LINE_N; k++) begin : g_dec
    assign line_hit[k] = (bus_addr == ADDR_W'(LINE_BASE + LINE_STEP * k));
  end
  assign mapped = cfg_hit | (|line_hit);

  lvl_irq_polarity #(
    .SRC_N      (SRC_N),
    .FIXED_SEL  (FIXED_SEL),
    .FIXED_HIGH (FIXED_HIGH)
  ) u_pol (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (bus_wr & cfg_hit),
    .cfg_wdata (bus_wdata[SRC_N-1:0]),
    .src_in    (src_in),
    .cfg_q     (cfg_q),
    .active    (active)
  );

  for (genvar k = 0; k < LINE_N; k++) begin : g_line
    lvl_irq_line #(
      .SRC_N    (SRC_N),
      .ID_W     (ID_W),
      .PEND_LSB (PEND_LSB)
    ) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (bus_wr & line_hit[k]),
      .wdata    (bus_wdata),
      .active   (active),
      .reg_word (line_word[k]),
      .irq      (irq_out[k]),
      .id       (irq_id[k*ID_W +: ID_W])
    );
  end

  always_comb begin
    rd_word = '0;
    if (cfg_hit) rd_word[SRC_N-1:0] = cfg_q;
    for (int k = 0; k < LINE_N; k++) begin
      if (line_hit[k]) rd_word = line_word[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  // R9: a read of an unmapped offset returns zero
  a_r9_unmapped_zero : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(bus_rd && !mapped) |-> bus_rdata == '0);

  // R11: read data holds when no read is strobed
  a_r11_rdata_hold : assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

// File: tb/lvl_irq_router_bench.sv
`timescale 1ns/1ps
module lvl_irq_router_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  src_in = 9'h0FD;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_out;
  logic [11:0] irq_id;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  lvl_irq_router u_lvl_irq_router (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .irq_id(irq_id)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issue a read and push the expected word onto the scoreboard
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compare each registered read word against the scoreboard
  always @(posedge clk) begin
    logic seen;
    seen = bus_rd;
    #1;
    if (seen && rst_n) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected read", bus_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  task automatic clear_lines();
    wr(5'h04, 32'h01FF0000);
    wr(5'h08, 32'h01FF0000);
    wr(5'h0C, 32'h01FF0000);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1: reset state, inputs held inactive under reset polarity
    check("R1 irq_out", 32'(irq_out), 32'h0);
    check("R1 irq_id", 32'(irq_id), 32'h0);
    rd(5'h00, 32'h0, "R1 polarity reg");
    rd(5'h04, 32'h0, "R1 line0 reg");
    rd(5'h0C, 32'h0, "R1 line2 reg");

    // R10: configure all configurable sources active-high, then clear
    src_in = 9'h004;
    wr(5'h00, 32'h000001FF);
    clear_lines();
    rd(5'h04, 32'h0, "R10 line0 after init");
    rd(5'h08, 32'h0, "R10 line1 after init");
    rd(5'h0C, 32'h0, "R10 line2 after init");
    rd(5'h00, 32'h1FF, "R2 polarity readback");

    // R2/R7/R8: source 3 active-high, enabled on line0 only
    wr(5'h04, 32'h00000008);
    src_in = 9'h00C;
    tick(2);
    check("R7 irq line0 on", 32'(irq_out), 32'h1);
    check("R8 id line0 src3", 32'(irq_id[3:0]), 32'd3);
    rd(5'h04, 32'h00080008, "R4 line0 mask and pending");
    rd(5'h08, 32'h00080000, "R5 line1 pending without mask");

    // R8: priority to higher-numbered sources
    src_in = 9'h02C;
    wr(5'h04, 32'h00000028);
    tick(2);
    check("R8 id src5", 32'(irq_id[3:0]), 32'd5);
    src_in = 9'h12C;
    wr(5'h04, 32'h00000128);
    tick(2);
    check("R8 id src8", 32'(irq_id[3:0]), 32'd8);
    rd(5'h04, 32'h01280128, "R5 line0 three pending");

    // R5: acknowledge while inputs still active -> sets again next edge
    wr(5'h04, 32'h01280128);
    tick(1);
    rd(5'h04, 32'h01280128, "R5 re-pend after ack");
    check("R7 irq stays", 32'(irq_out[0]), 32'h1);

    // R6: drop inputs then acknowledge -> stays clear
    src_in = 9'h004;
    wr(5'h04, 32'h01280128);
    rd(5'h04, 32'h00000128, "R6 ack clears");
    tick(2);
    check("R7 irq line0 off", 32'(irq_out[0]), 32'h0);
    check("R8 id zero when idle", 32'(irq_id[3:0]), 32'h0);
    clear_lines();

    // R6: writing 0 in pending half leaves bits; R4: mask overwritten
    src_in = 9'h00C;
    wr(5'h0C, 32'h00000008);
    tick(2);
    check("R7 irq line2 on", 32'(irq_out), 32'h4);
    src_in = 9'h004;
    wr(5'h0C, 32'h00000000);
    tick(2);
    check("R4 mask cleared drops irq", 32'(irq_out), 32'h0);
    rd(5'h0C, 32'h00080000, "R6 zero write keeps pending");
    clear_lines();

    // R3: fixed sources ignore the polarity register
    src_in = 9'h0FD;
    wr(5'h00, 32'h00000000);
    clear_lines();
    rd(5'h04, 32'h0, "R3 fixed sources inactive at cfg 0");
    src_in = 9'h0FF;
    tick(2);
    rd(5'h04, 32'h00020000, "R3 src1 fixed active-high");
    src_in = 9'h0FD;
    wr(5'h00, 32'h00000004);
    clear_lines();
    rd(5'h08, 32'h0, "R3 src2 cfg bit ignored");

    // R2: configurable active-low
    wr(5'h00, 32'h00000000);
    src_in = 9'h0ED;
    tick(2);
    rd(5'h08, 32'h00100000, "R2 src4 active-low");
    src_in = 9'h0FD;
    clear_lines();
    rd(5'h08, 32'h0, "R2 src4 cleared");

    // R9: unmapped and unaligned offsets
    wr(5'h10, 32'hFFFFFFFF);
    wr(5'h02, 32'h000001FF);
    rd(5'h10, 32'h0, "R9 unmapped read");
    rd(5'h02, 32'h0, "R9 unaligned read");
    rd(5'h00, 32'h0, "R9 polarity unchanged");
    rd(5'h04, 32'h0, "R9 line0 unchanged");

    // R9: reserved bits read zero; R8 priority 7 over 1
    wr(5'h04, 32'hFFFFFFFF);
    rd(5'h04, 32'h000001FF, "R9 reserved bits zero");
    src_in = 9'h07F;
    tick(2);
    check("R7 irq line0 src7", 32'(irq_out), 32'h1);
    check("R8 id src7 over src1", 32'(irq_id[3:0]), 32'd7);
    rd(5'h04, 32'h008201FF, "R5 line0 src7 and src1");

    // R11: read data holds without a strobe
    tick(3);
    check("R11 rdata hold", bus_rdata, 32'h008201FF);

    tick(3);
    if (exp_q.size() != 0) check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
  end

endmodule